// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block holds the inter-processor interrupt state for a cluster of up to 31 CPUs. Each CPU owns two interrupt kinds: a "remote" kind, which any CPU may raise on any set of targets with one write of a CPU bitmap, and a "self" kind, which a CPU raises only on itself. Each kind has its own pending flag and its own mask flag. Software reaches the state through one write port. It may use a local window, where the writing CPU is named by a sideband index, or an explicit per-CPU window, where the CPU index sits in the address.

For each CPU the unit offers one request to a downstream event encoder, tagged with the event number of the kind it presents. When the encoder reports through a per-CPU strobe that the presented interrupt has been taken, the unit sets that kind's mask. Software must clear the mask before the next interrupt of that kind can be presented. The pending flag is cleared only by an explicit acknowledge.

Top module: `ipi_unit`

## Requirements
- R1: After reset every pending flag is 0, every mask flag is 1, and no request is raised, even after sends arrive, until a mask is cleared.
- R2: A write to the send register (offset 0x08) with bit k set, for k below NCPU, sets the remote pending flag of CPU k. Several bits may be set in one write. A CPU may target itself, with the same result as a remote send. Bits from NCPU to 30 are ignored.
- R3: Bit 31 of a send write sets the self pending flag of the writing CPU only.
- R4: A write to the acknowledge register (offset 0x0C) clears the writing CPU's remote pending flag when bit 0 is 1 and its self pending flag when bit 31 is 1. Other CPUs are not affected.
- R5: Writing 1s to mask-set (offset 0x24) or mask-clear (offset 0x28) sets or clears the writing CPU's remote mask (bit 0) and self mask (bit 31). Bits written as 0 leave the flags unchanged.
- R6: A CPU's request is high exactly when some kind is both pending and unmasked. Its event number (2 bits per CPU, CPU k at bits 2k+1:2k) is 1 for remote and 2 for self, and remote wins when both qualify.
- R7: A delivery strobe for a CPU with a raised request sets the mask of the presented kind and leaves the pending flags alone. A strobe with no request raised changes nothing.
- R8: When a delivery strobe and a mask-clear of the same kind on the same CPU fall in one cycle, the mask ends up set.
- R9: Address bits 15:12 pick the window. Value 0 is the local window: bits 11:7 must be 0 and the CPU is wr_cpu. Value 1 is the per-CPU window: bits 11:7 give the CPU. Bits 6:0 give the offset. A write naming a CPU at or above NCPU, using another window value, or using an unmapped offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_cpu | input | CPU_W | Index of the CPU issuing a local-window write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| dlv | input | NCPU | Per-CPU delivery strobe from the event encoder |
| ev_req | output | NCPU | Per-CPU interrupt request |
| ev_num | output | 2*NCPU | Per-CPU event number, 1 remote, 2 self |

## Verification
The bench goes after priority between the kinds: a unit that picks self first would report event 2 while a remote interrupt is ready. Delivery is driven with nothing presented and together with a mask-clear. A design that masks blindly would lose a later interrupt, and one that lets the clear win would present the same interrupt twice. Sends with bits above the CPU count, writes through out-of-range per-CPU windows and writes to unmapped offsets are issued. A loose decoder would corrupt another CPU's state. A long random phase compares every CPU's request and event number with a behavioural model on every clock.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned OFS_W    = 7;
   localparam int unsigned VIEW_LSB = 12;
   localparam int unsigned CPUF_LSB = 7;
   localparam int unsigned CPUF_W   = 5;

   localparam logic [OFS_W-1:0] OFS_SEND = 7'h08;
   localparam logic [OFS_W-1:0] OFS_ACK  = 7'h0C;
   localparam logic [OFS_W-1:0] OFS_MSET = 7'h24;
   localparam logic [OFS_W-1:0] OFS_MCLR = 7'h28;

   localparam int unsigned REMOTE_BIT = 0;
   localparam int unsigned SELF_BIT   = 31;

   localparam logic [1:0] NUM_REMOTE = 2'd1;
   localparam logic [1:0] NUM_SELF   = 2'd2;

   localparam logic [3:0] WIN_LOCAL  = 4'h0;
   localparam logic [3:0] WIN_PERCPU = 4'h1;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_SEND,
      CMD_ACK,
      CMD_MSET,
      CMD_MCLR
   } cmd_e;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
   import ipi_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned CPU_W  = 2,
   parameter int unsigned ADDR_W = 16
) (
   input  logic              wr_en,
   input  logic [CPU_W-1:0]  wr_cpu,
   input  logic [ADDR_W-1:0] wr_addr,
   output cmd_e              cmd,
   output logic [CPU_W-1:0]  tgt_cpu
);

   localparam int unsigned WIN_W = ADDR_W - VIEW_LSB;

   logic [WIN_W-1:0]  win;
   logic [CPUF_W-1:0] cpu_fld;
   logic [OFS_W-1:0]  ofs;
   logic              hit;

   assign win     = wr_addr[ADDR_W-1:VIEW_LSB];
   assign cpu_fld = wr_addr[CPUF_LSB +: CPUF_W];
   assign ofs     = wr_addr[OFS_W-1:0];

   always_comb begin
      hit     = 1'b0;
      tgt_cpu = '0;
      if (wr_en) begin
         if (win == WIN_W'(WIN_LOCAL)) begin
            if (cpu_fld == '0 && 32'(wr_cpu) < NCPU) begin
               hit     = 1'b1;
               tgt_cpu = wr_cpu;
            end
         end else if (win == WIN_W'(WIN_PERCPU)) begin
            if (32'(cpu_fld) < NCPU) begin
               hit     = 1'b1;
               tgt_cpu = CPU_W'(cpu_fld);
            end
         end
      end
   end

   always_comb begin
      cmd = CMD_NONE;
      if (hit) begin
         unique case (ofs)
            OFS_SEND: cmd = CMD_SEND;
            OFS_ACK:  cmd = CMD_ACK;
            OFS_MSET: cmd = CMD_MSET;
            OFS_MCLR: cmd = CMD_MCLR;
            default:  cmd = CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
   import ipi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raise_r,
   input  logic       raise_s,
   input  logic       ack_r,
   input  logic       ack_s,
   input  logic       mset_r,
   input  logic       mset_s,
   input  logic       mclr_r,
   input  logic       mclr_s,
   input  logic       dlv,
   output logic       req,
   output logic [1:0] num
);

   logic pend_r, pend_s, mask_r, mask_s;
   logic live_r, live_s;
   logic take_r, take_s;

   assign live_r = pend_r & ~mask_r;
   assign live_s = pend_s & ~mask_s;
   assign req    = live_r | live_s;
   assign num    = live_r ? NUM_REMOTE : NUM_SELF;

   // delivery masks only the kind being presented
   assign take_r = dlv & live_r;
   assign take_s = dlv & ~live_r & live_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_r <= 1'b0;
         pend_s <= 1'b0;
         mask_r <= 1'b1;
         mask_s <= 1'b1;
      end else begin
         pend_r <= raise_r | (pend_r & ~ack_r);
         pend_s <= raise_s | (pend_s & ~ack_s);
         mask_r <= take_r | mset_r | (mask_r & ~mclr_r);
         mask_s <= take_s | mset_s | (mask_s & ~mclr_s);
      end
   end

   p_send_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      raise_r |=> pend_r);
   p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_r && !raise_r) |=> !pend_r);
   p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mclr_s && !mset_s && !dlv) |=> !mask_s);
   p_req_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (pend_r || pend_s));
   p_delivery_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv && live_r) |=> mask_r);
   p_delivery_keeps_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv && pend_r && !ack_r) |=> pend_r);
   p_dlv_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv && live_r && mclr_r) |=> !live_r);

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
   import ipi_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned ADDR_W = 16,
   localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CPU_W-1:0]    wr_cpu,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic [NCPU-1:0]     dlv,
   output logic [NCPU-1:0]     ev_req,
   output logic [2*NCPU-1:0]   ev_num
);

   generate
      if (NCPU < 1 || NCPU > SELF_BIT) begin : g_bad_ncpu
         $error("ipi_unit: NCPU must lie in 1..31");
      end
      if (ADDR_W < VIEW_LSB + 1) begin : g_bad_addr
         $error("ipi_unit: ADDR_W too small for the window field");
      end
   endgenerate

   cmd_e             cmd;
   logic [CPU_W-1:0] tgt_cpu;
   logic             unused_data;

   assign unused_data = ^wr_data;

   ipi_addr_decode #(
      .NCPU   (NCPU),
      .CPU_W  (CPU_W),
      .ADDR_W (ADDR_W)
   ) u_decode (
      .wr_en   (wr_en),
      .wr_cpu  (wr_cpu),
      .wr_addr (wr_addr),
      .cmd     (cmd),
      .tgt_cpu (tgt_cpu)
   );

   logic b_r, b_s;
   assign b_r = wr_data[REMOTE_BIT];
   assign b_s = wr_data[SELF_BIT];

   for (genvar k = 0; k < NCPU; k++) begin : g_cpu
      logic mine;
      assign mine = (tgt_cpu == CPU_W'(k));

      ipi_cpu_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .raise_r (cmd == CMD_SEND && wr_data[k]),
         .raise_s (cmd == CMD_SEND && mine && b_s),
         .ack_r   (cmd == CMD_ACK  && mine && b_r),
         .ack_s   (cmd == CMD_ACK  && mine && b_s),
         .mset_r  (cmd == CMD_MSET && mine && b_r),
         .mset_s  (cmd == CMD_MSET && mine && b_s),
         .mclr_r  (cmd == CMD_MCLR && mine && b_r),
         .mclr_s  (cmd == CMD_MCLR && mine && b_s),
         .dlv     (dlv[k]),
         .req     (ev_req[k]),
         .num     (ev_num[2*k +: 2])
      );

      p_self_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd == CMD_SEND && b_s && !mine && !ev_req[k]) |=> !ev_req[k] || $past(wr_data[k]));
   end

   p_cmd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NONE) |-> wr_en);
   p_num_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_req[0] |-> (ev_num[1:0] == NUM_REMOTE || ev_num[1:0] == NUM_SELF));

endmodule

// File: tb/ipi_unit_test.sv
module ipi_unit_test;

   localparam int N      = 4;
   localparam int PERIOD = 10;
   localparam int CW     = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [CW-1:0]   wr_cpu = '0;
   logic [15:0]     wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [N-1:0]    dlv = '0;
   logic [N-1:0]    ev_req;
   logic [2*N-1:0]  ev_num;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit live = 0;

   always #(PERIOD/2) clk = ~clk;

   ipi_unit #(.NCPU(N), .ADDR_W(16)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_cpu  (wr_cpu),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .dlv     (dlv),
      .ev_req  (ev_req),
      .ev_num  (ev_num)
   );

   // behavioural reference model
   logic [N-1:0] m_pr, m_ps, m_mr, m_ms;
   logic [N-1:0] n_pr, n_ps, n_mr, n_ms;
   int  mc, moff, mwin, mfld;
   bit  mok;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pr <= '0; m_ps <= '0; m_mr <= '1; m_ms <= '1;
      end else begin
         n_pr = m_pr; n_ps = m_ps; n_mr = m_mr; n_ms = m_ms;
         mok  = 0; mc = 0;
         mwin = int'(wr_addr) >> 12;
         mfld = (int'(wr_addr) >> 7) & 31;
         moff = int'(wr_addr) & 'h7F;
         if (wr_en) begin
            if (mwin == 0 && mfld == 0 && int'(wr_cpu) < N) begin mok = 1; mc = int'(wr_cpu); end
            else if (mwin == 1 && mfld < N) begin mok = 1; mc = mfld; end
         end
         if (mok) begin
            case (moff)
               'h08: begin
                  for (int k = 0; k < N; k++) if (wr_data[k]) n_pr[k] = 1'b1;
                  if (wr_data[31]) n_ps[mc] = 1'b1;
               end
               'h0C: begin
                  if (wr_data[0])  n_pr[mc] = 1'b0;
                  if (wr_data[31]) n_ps[mc] = 1'b0;
               end
               'h24: begin
                  if (wr_data[0])  n_mr[mc] = 1'b1;
                  if (wr_data[31]) n_ms[mc] = 1'b1;
               end
               'h28: begin
                  if (wr_data[0])  n_mr[mc] = 1'b0;
                  if (wr_data[31]) n_ms[mc] = 1'b0;
               end
               default: ;
            endcase
         end
         for (int k = 0; k < N; k++) begin
            if (dlv[k]) begin
               if (m_pr[k] && !m_mr[k])      n_mr[k] = 1'b1;
               else if (m_ps[k] && !m_ms[k]) n_ms[k] = 1'b1;
            end
         end
         m_pr <= n_pr; m_ps <= n_ps; m_mr <= n_mr; m_ms <= n_ms;
      end
   end

   function automatic logic [N-1:0] exp_req();
      return (m_pr & ~m_mr) | (m_ps & ~m_ms);
   endfunction

   function automatic logic [2*N-1:0] exp_num();
      logic [2*N-1:0] v = '0;
      for (int k = 0; k < N; k++)
         v[2*k +: 2] = (m_pr[k] && !m_mr[k]) ? 2'd1 : 2'd2;
      return v;
   endfunction

   function automatic logic [2*N-1:0] num_masked(input logic [2*N-1:0] v, input logic [N-1:0] r);
      logic [2*N-1:0] o = '0;
      for (int k = 0; k < N; k++) if (r[k]) o[2*k +: 2] = v[2*k +: 2];
      return o;
   endfunction

   // per-clock comparison against the model (R6)
   always @(negedge clk) begin
      if (live && !done) begin
         checks++;
         if (ev_req !== exp_req() ||
             num_masked(ev_num, exp_req()) !== num_masked(exp_num(), exp_req())) begin
            errors++;
            $display("FAIL R6 model compare: req=%b num=%b expected req=%b num=%b",
                     ev_req, num_masked(ev_num, exp_req()), exp_req(),
                     num_masked(exp_num(), exp_req()));
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cyc(input int cpu, input int addr, input logic [31:0] d,
                      input logic en, input logic [N-1:0] dv);
      @(negedge clk); #1;
      wr_en = en; wr_cpu = CW'(cpu); wr_addr = 16'(addr); wr_data = d; dlv = dv;
      @(negedge clk); #1;
      wr_en = 1'b0; dlv = '0;
   endtask

   task automatic wr(input int cpu, input int addr, input logic [31:0] d);
      cyc(cpu, addr, d, 1'b1, '0);
   endtask

   function automatic int pc(input int c, input int ofs);
      return 'h1000 + (c << 7) + ofs;
   endfunction

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      live = 1;
      @(negedge clk); #1;
      chk("R1 reset request", 32'(ev_req), 32'h0);

      wr(0, 'h08, 32'h6);
      chk("R1 masked after reset", 32'(ev_req), 32'h0);

      wr(1, 'h28, 32'h1);
      chk("R2/R5 cpu1 remote req", 32'(ev_req), 32'h2);
      chk("R6 cpu1 number", 32'(ev_num[3:2]), 32'h1);

      wr(2, pc(2, 'h28), 32'h1);
      chk("R9 per-cpu unmask", 32'(ev_req), 32'h6);

      wr(3, 'h08, 32'h8);
      wr(3, 'h28, 32'h1);
      chk("R2 self target", 32'(ev_req), 32'hE);

      wr(0, 'h28, 32'h1);
      wr(0, 'h08, 32'h30);
      chk("R2 high bits ignored", 32'(ev_req), 32'hE);

      wr(0, 'h08, 32'h8000_0000);
      wr(0, 'h28, 32'h8000_0000);
      chk("R3 self raise cpu0", 32'(ev_req), 32'hF);
      chk("R6 self number", 32'(ev_num[1:0]), 32'h2);

      wr(0, 'h08, 32'h1);
      chk("R6 remote priority", 32'(ev_num[1:0]), 32'h1);

      cyc(0, 0, 32'h0, 1'b0, 4'h1);
      chk("R7 delivery masks remote", 32'(ev_num[1:0]), 32'h2);
      wr(0, 'h28, 32'h1);
      chk("R7 pending kept", 32'(ev_num[1:0]), 32'h1);

      wr(0, 'h0C, 32'h1);
      chk("R4 ack remote", 32'(ev_num[1:0]), 32'h2);
      wr(0, 'h0C, 32'h8000_0000);
      chk("R4 ack self", 32'(ev_req), 32'hE);

      cyc(0, 0, 32'h0, 1'b0, 4'h1);
      wr(0, 'h08, 32'h1);
      chk("R7 idle delivery ignored", 32'(ev_req), 32'hF);

      cyc(0, 'h28, 32'h1, 1'b1, 4'h1);
      chk("R8 delivery beats clear", 32'(ev_req), 32'hE);

      wr(1, 'h10, 32'h8000_0001);
      wr(1, pc(7, 'h24), 32'h1);
      wr(1, 'h0080 + 'h24, 32'h1);
      wr(1, 'h2000 + 'h24, 32'h1);
      chk("R9 stray writes ignored", 32'(ev_req), 32'hE);

      wr(0, pc(1, 'h24), 32'h1);
      chk("R9 view acts for cpu1", 32'(ev_req), 32'hC);

      wr(2, 'h0C, 32'h0);
      chk("R4 zero ack no effect", 32'(ev_req), 32'hC);

      for (int i = 0; i < 3000; i++) begin
         int sel, cpu, addr;
         logic [31:0] d;
         sel  = int'($urandom_range(0, 4));
         cpu  = int'($urandom_range(0, N - 1));
         d    = {$urandom_range(0, 1) == 1, 26'h0, 5'($urandom)};
         case (sel)
            0: addr = 'h08;
            1: addr = 'h0C;
            2: addr = 'h24;
            3: addr = 'h28;
            default: addr = 'h30;
         endcase
         if ($urandom_range(0, 1) == 1) addr = pc(int'($urandom_range(0, 5)), addr);
         cyc(cpu, addr, d, $urandom_range(0, 3) != 0, N'($urandom));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule